// File: doc/BRIEF.md
# MSI-X Capability and Vector Table Register File

This block holds the software-visible state of an MSI-X capable function: the capability words and the per-vector message table. Software reaches both through one memory-mapped access port. A region select bit picks the capability words or the vector table, and each access carries a byte offset and a size. Each vector entry is 16 bytes long. It can be read or written one DWORD at a time, or one QWORD at a time for an aligned pair of fields.

The capability words report the fixed table geometry and where the table and pending array sit in the function's memory windows. Only the global enable and the function-wide mask can be changed, and only through a 2-byte write to the control half-word.

Interrupt dispatch logic looks up any vector index through a side query port. For that vector it gets the mask state, the message address and the message data. While MSI-X is enabled, any table write that changes a vector's address or data raises a one-cycle route-update pulse carrying the vector index, so that the downstream routing can be refreshed.

Top module: `msix_regs`

## Requirements
- R1: After reset, enable and function mask are 0, no response or route pulse is pending, and every vector reads as unmasked with zero address and zero data.
- R2: A 4-byte table access at entry offset 0x0, 0x4, 0x8 or 0xC reaches address low, address high, message data or vector control respectively, and the vector index is the byte offset divided by 16. Read data is zero-extended to 64 bits.
- R3: An 8-byte table access at entry offset 0x0 carries address low in bits 31:0 and address high in bits 63:32. At entry offset 0x8 it carries message data in bits 31:0 and vector control in bits 63:32.
- R4: Vector control keeps only bit 0, the per-vector mask (1 = masked). Every other bit reads as 0, and the query port reports the stored bit as the mask.
- R5: A 4-byte capability read at offset 0 returns the capability ID in bits 7:0, the next pointer in bits 15:8, the table size minus one in bits 26:16, zero in bits 29:27, the function mask in bit 30 and the enable in bit 31.
- R6: A 2-byte capability write at offset 2 updates the enable from write-data bit 15 and the function mask from bit 14, and ignores the other bits. Any other capability write gets an error response and changes nothing.
- R7: 4-byte capability reads at offsets 4 and 8 return the table location word and the pending-array location word. Each carries the window indicator in bits 2:0 and the 8-byte-aligned offset in bits 31:3.
- R8: A query for a vector index at or beyond the table size reports the vector as masked, with zero address and data.
- R9: While enabled, a table write that changes address low, address high or data of a vector gives route_upd high for exactly the response cycle, with route_idx equal to that vector. A write that changes none of them, a vector-control write, or any write while disabled gives no pulse.
- R10: A table access whose size is not 4 or 8, whose offset is not aligned to its size, or whose vector index is beyond the table, and any capability read other than a 4-byte read at 0, 4 or 8, gets an error response with zero read data and changes no state.
- R11: Every accepted request gets exactly one response, with rsp_valid high in the cycle after the request; rsp_valid is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request for this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_table | input | 1 | 1 = vector table region, 0 = capability words |
| acc_offset | input | ADDR_W | Byte offset within the selected region |
| acc_size | input | 4 | Access size in bytes |
| acc_wdata | input | 64 | Write data, least significant byte at the lowest offset |
| rsp_valid | output | 1 | Response strobe, one cycle after each request |
| rsp_rdata | output | 64 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | The access was rejected |
| msix_en | output | 1 | Global MSI-X enable |
| fn_mask | output | 1 | Function-wide mask |
| qry_idx | input | QIDX_W | Vector index looked up by dispatch |
| qry_masked | output | 1 | The queried vector is masked or out of range |
| qry_addr | output | 64 | Message address of the queried vector |
| qry_data | output | 32 | Message data of the queried vector |
| route_upd | output | 1 | Route-update pulse for a changed live vector |
| route_idx | output | IDX_W | Vector index carried by the route-update pulse |

## Verification
The assertions assume that the access inputs are stable and free of X whenever acc_valid is high, and that software issues at most one request per cycle and never needs a response before the following cycle. The bench keeps to this by driving all request fields on the falling edge, holding them through one rising edge, and dropping acc_valid before the next one. It only changes qry_idx between edges. The route-update checks rely on the pulse appearing alongside the write's response and on no other write intervening, so the bench samples route_upd in the response cycle and once more in the cycle after it.

// File: rtl/msix_pkg.sv
package msix_pkg;

   typedef enum logic [2:0] {
      OP_BAD    = 3'd0,
      OP_CAP_RD = 3'd1,
      OP_CAP_WR = 3'd2,
      OP_TBL_RD = 3'd3,
      OP_TBL_WR = 3'd4
   } msix_op_e;

   typedef struct packed {
      logic [31:0] addr_hi;
      logic [31:0] addr_lo;
      logic [31:0] data;
      logic        mask;
   } msix_entry_t;

   localparam int unsigned MSIX_MAX_VEC  = 2048;
   localparam int unsigned ENTRY_BYTES   = 16;
   localparam logic [3:0]  CTL_WR_OFFSET = 4'd2;

endpackage

// File: rtl/msix_acc_decode.sv
module msix_acc_decode
   import msix_pkg::*;
#(
   parameter int unsigned NUM_VEC = 16,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned IDX_W   = 4
) (
   input  logic              acc_table,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_offset,
   input  logic [3:0]        acc_size,
   output msix_op_e          op,
   output logic [1:0]        cap_sel,
   output logic [IDX_W-1:0]  tbl_idx,
   output logic [1:0]        tbl_slot,
   output logic              tbl_qword
);

   localparam int unsigned EW = ADDR_W - 4;
   localparam logic [EW-1:0] NV_E = EW'(NUM_VEC);
   localparam logic [ADDR_W-1:0] CAP_END = ADDR_W'(12);

   logic [EW-1:0] ent_num;
   logic          in_range;
   logic          dw_ok;
   logic          qw_ok;

   assign ent_num   = acc_offset[ADDR_W-1:4];
   assign in_range  = ent_num < NV_E;
   assign dw_ok     = (acc_size == 4'd4) && (acc_offset[1:0] == 2'b00);
   assign qw_ok     = (acc_size == 4'd8) && (acc_offset[2:0] == 3'b000);
   assign tbl_idx   = ent_num[IDX_W-1:0];
   assign tbl_slot  = acc_offset[3:2];
   assign tbl_qword = (acc_size == 4'd8);
   assign cap_sel   = acc_offset[3:2];

   always_comb begin
      op = OP_BAD;
      if (!acc_table) begin
         if (acc_write) begin
            if (acc_size == 4'd2 && acc_offset == ADDR_W'(CTL_WR_OFFSET))
               op = OP_CAP_WR;
         end else if (dw_ok && acc_offset < CAP_END) begin
            op = OP_CAP_RD;
         end
      end else if ((dw_ok || qw_ok) && in_range) begin
         op = acc_write ? OP_TBL_WR : OP_TBL_RD;
      end
   end

endmodule

// File: rtl/msix_cap_regs.sv
module msix_cap_regs
   import msix_pkg::*;
#(
   parameter int unsigned NUM_VEC  = 16,
   parameter logic [7:0]  CAP_ID   = 8'h11,
   parameter logic [7:0]  NEXT_PTR = 8'h00,
   parameter logic [2:0]  TBL_BIR  = 3'd0,
   parameter logic [31:0] TBL_OFF  = 32'h0000_2000,
   parameter logic [2:0]  PBA_BIR  = 3'd4,
   parameter logic [31:0] PBA_OFF  = 32'h0000_3000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wr_half,
   input  logic [1:0]  rd_sel,
   output logic [31:0] rd_word,
   output logic        msix_en,
   output logic        fn_mask
);

   localparam logic [10:0] SIZE_M1 = 11'(NUM_VEC - 1);
   localparam logic [31:0] TBL_WORD = {TBL_OFF[31:3], TBL_BIR};
   localparam logic [31:0] PBA_WORD = {PBA_OFF[31:3], PBA_BIR};

   if (TBL_BIR > 3'd5) begin : g_bad_tbl_bir
      $error("msix_cap_regs: table window indicator above 5");
   end
   if (PBA_BIR > 3'd5) begin : g_bad_pba_bir
      $error("msix_cap_regs: pending-array window indicator above 5");
   end
   if (TBL_OFF[2:0] != 3'd0 || PBA_OFF[2:0] != 3'd0) begin : g_bad_align
      $error("msix_cap_regs: location offsets must be 8-byte aligned");
   end

   logic en_q;
   logic fm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         fm_q <= 1'b0;
      end else if (wr_en) begin
         en_q <= wr_half[15];
         fm_q <= wr_half[14];
      end
   end

   assign msix_en = en_q;
   assign fn_mask = fm_q;

   logic [15:0] ctl_word;
   assign ctl_word = {en_q, fm_q, 3'b000, SIZE_M1};

   always_comb begin
      unique case (rd_sel)
         2'd0:    rd_word = {ctl_word, NEXT_PTR, CAP_ID};
         2'd1:    rd_word = TBL_WORD;
         2'd2:    rd_word = PBA_WORD;
         default: rd_word = 32'd0;
      endcase
   end

   // Control bits only move on an accepted control write (R6).
   p_ctl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({en_q, fm_q}));

   // Reserved control bits read as zero (R5).
   p_ctl_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == 2'd0) |-> (rd_word[29:27] == 3'b000));

endmodule

// File: rtl/msix_vec_table.sv
module msix_vec_table
   import msix_pkg::*;
#(
   parameter int unsigned NUM_VEC = 16,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned QIDX_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [1:0]        slot,
   input  logic              qword,
   input  logic [63:0]       wdata,
   output logic [63:0]       rd_data,
   output logic              chg,
   input  logic [QIDX_W-1:0] qry_idx,
   output logic              qry_masked,
   output logic [63:0]       qry_addr,
   output logic [31:0]       qry_data
);

   localparam logic [IDX_W:0]    NV_I = (IDX_W+1)'(NUM_VEC);
   localparam logic [QIDX_W-1:0] NV_Q = QIDX_W'(NUM_VEC);

   msix_entry_t [NUM_VEC-1:0] ent;
   msix_entry_t cur;
   msix_entry_t nxt;
   msix_entry_t qent;
   logic        idx_ok;
   logic        q_ok;

   assign idx_ok = {1'b0, idx} < NV_I;
   assign cur    = idx_ok ? ent[idx] : '0;

   always_comb begin
      nxt = cur;
      if (qword) begin
         if (!slot[1]) begin
            nxt.addr_lo = wdata[31:0];
            nxt.addr_hi = wdata[63:32];
         end else begin
            nxt.data = wdata[31:0];
            nxt.mask = wdata[32];
         end
      end else begin
         unique case (slot)
            2'd0: nxt.addr_lo = wdata[31:0];
            2'd1: nxt.addr_hi = wdata[31:0];
            2'd2: nxt.data    = wdata[31:0];
            2'd3: nxt.mask    = wdata[0];
         endcase
      end
   end

   assign chg = wr_en && ({nxt.addr_hi, nxt.addr_lo, nxt.data} !=
                          {cur.addr_hi, cur.addr_lo, cur.data});

   for (genvar e = 0; e < NUM_VEC; e++) begin : g_ent
      msix_entry_t r;
      logic        hit;
      assign hit = wr_en && idx_ok && (idx == IDX_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   r <= '0;
         else if (hit) r <= nxt;
      end
      assign ent[e] = r;
   end

   always_comb begin
      if (qword) begin
         rd_data = slot[1] ? {31'd0, cur.mask, cur.data}
                           : {cur.addr_hi, cur.addr_lo};
      end else begin
         unique case (slot)
            2'd0: rd_data = {32'd0, cur.addr_lo};
            2'd1: rd_data = {32'd0, cur.addr_hi};
            2'd2: rd_data = {32'd0, cur.data};
            2'd3: rd_data = {63'd0, cur.mask};
         endcase
      end
   end

   assign q_ok       = qry_idx < NV_Q;
   assign qent       = q_ok ? ent[qry_idx[IDX_W-1:0]] : '0;
   assign qry_masked = !q_ok || qent.mask;
   assign qry_addr   = {qent.addr_hi, qent.addr_lo};
   assign qry_data   = qent.data;

   // Vector control DWORD exposes only the mask bit (R4).
   p_vctl_bit0_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!qword && slot == 2'd3) |-> (rd_data[63:1] == 63'd0));

   // An out-of-range query never yields a live message (R8).
   p_oob_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !q_ok |-> (qry_addr == 64'd0 && qry_data == 32'd0));

endmodule

// File: rtl/msix_regs.sv
module msix_regs
   import msix_pkg::*;
#(
   parameter int unsigned NUM_VEC  = 16,
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned QIDX_W   = 12,
   parameter logic [7:0]  CAP_ID   = 8'h11,
   parameter logic [7:0]  NEXT_PTR = 8'h00,
   parameter logic [2:0]  TBL_BIR  = 3'd0,
   parameter logic [31:0] TBL_OFF  = 32'h0000_2000,
   parameter logic [2:0]  PBA_BIR  = 3'd4,
   parameter logic [31:0] PBA_OFF  = 32'h0000_3000,
   localparam int unsigned IDX_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic              acc_table,
   input  logic [ADDR_W-1:0] acc_offset,
   input  logic [3:0]        acc_size,
   input  logic [63:0]       acc_wdata,
   output logic              rsp_valid,
   output logic [63:0]       rsp_rdata,
   output logic              rsp_err,
   output logic              msix_en,
   output logic              fn_mask,
   input  logic [QIDX_W-1:0] qry_idx,
   output logic              qry_masked,
   output logic [63:0]       qry_addr,
   output logic [31:0]       qry_data,
   output logic              route_upd,
   output logic [IDX_W-1:0]  route_idx
);

   if (NUM_VEC < 1 || NUM_VEC > MSIX_MAX_VEC) begin : g_bad_nvec
      $error("msix_regs: NUM_VEC must be 1 to 2048");
   end
   if (ADDR_W < IDX_W + 5) begin : g_bad_addr
      $error("msix_regs: ADDR_W too narrow for the table");
   end
   if (QIDX_W <= IDX_W) begin : g_bad_qidx
      $error("msix_regs: QIDX_W must exceed the index width");
   end

   msix_op_e         op;
   logic [1:0]       cap_sel;
   logic [IDX_W-1:0] tbl_idx;
   logic [1:0]       tbl_slot;
   logic             tbl_qword;
   logic [31:0]      cap_word;
   logic [63:0]      tbl_word;
   logic             tbl_chg;
   logic             cap_we;
   logic             tbl_we;

   msix_acc_decode #(
      .NUM_VEC (NUM_VEC),
      .ADDR_W  (ADDR_W),
      .IDX_W   (IDX_W)
   ) u_dec (
      .acc_table  (acc_table),
      .acc_write  (acc_write),
      .acc_offset (acc_offset),
      .acc_size   (acc_size),
      .op         (op),
      .cap_sel    (cap_sel),
      .tbl_idx    (tbl_idx),
      .tbl_slot   (tbl_slot),
      .tbl_qword  (tbl_qword)
   );

   assign cap_we = acc_valid && (op == OP_CAP_WR);
   assign tbl_we = acc_valid && (op == OP_TBL_WR);

   msix_cap_regs #(
      .NUM_VEC  (NUM_VEC),
      .CAP_ID   (CAP_ID),
      .NEXT_PTR (NEXT_PTR),
      .TBL_BIR  (TBL_BIR),
      .TBL_OFF  (TBL_OFF),
      .PBA_BIR  (PBA_BIR),
      .PBA_OFF  (PBA_OFF)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cap_we),
      .wr_half (acc_wdata[15:0]),
      .rd_sel  (cap_sel),
      .rd_word (cap_word),
      .msix_en (msix_en),
      .fn_mask (fn_mask)
   );

   msix_vec_table #(
      .NUM_VEC (NUM_VEC),
      .IDX_W   (IDX_W),
      .QIDX_W  (QIDX_W)
   ) u_tbl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (tbl_we),
      .idx        (tbl_idx),
      .slot       (tbl_slot),
      .qword      (tbl_qword),
      .wdata      (acc_wdata),
      .rd_data    (tbl_word),
      .chg        (tbl_chg),
      .qry_idx    (qry_idx),
      .qry_masked (qry_masked),
      .qry_addr   (qry_addr),
      .qry_data   (qry_data)
   );

   logic [63:0] rd_mux;
   always_comb begin
      unique case (op)
         OP_CAP_RD: rd_mux = {32'd0, cap_word};
         OP_TBL_RD: rd_mux = tbl_word;
         default:   rd_mux = 64'd0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= 64'd0;
         rsp_err   <= 1'b0;
         route_upd <= 1'b0;
         route_idx <= '0;
      end else begin
         rsp_valid <= acc_valid;
         rsp_rdata <= acc_valid ? rd_mux : 64'd0;
         rsp_err   <= acc_valid && (op == OP_BAD);
         route_upd <= tbl_we && tbl_chg && msix_en;
         if (tbl_we) route_idx <= tbl_idx;
      end
   end

   // One response per request, one cycle later (R11).
   p_rsp_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid);
   p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !rsp_valid);

   // Rejected accesses return zero data (R10).
   p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == 64'd0));

   // A route pulse needs an enabled table write in the cycle before (R9).
   p_route_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      route_upd |-> $past(acc_valid && acc_write && acc_table && msix_en));

endmodule

// File: tb/msix_regs_bench.sv
module msix_regs_bench;

   typedef struct packed {
      logic [3:0]  req;
      logic        wr;
      logic        tbl;
      logic [15:0] off;
      logic [3:0]  sz;
      logic [63:0] wd;
      logic [63:0] exp;
      logic        err;
   } vec_t;

   localparam int NV = 30;
   // Tags: R2 R3 R4 R5 R6 R7 R10 exercised by the table below.
   localparam vec_t VECS [NV] = '{
      '{4'd5,  1'b0, 1'b0, 16'h0000, 4'd4, 64'h0, 64'h0000_0000_000F_0011, 1'b0},
      '{4'd7,  1'b0, 1'b0, 16'h0004, 4'd4, 64'h0, 64'h0000_0000_0000_2000, 1'b0},
      '{4'd7,  1'b0, 1'b0, 16'h0008, 4'd4, 64'h0, 64'h0000_0000_0000_3004, 1'b0},
      '{4'd1,  1'b0, 1'b1, 16'h0030, 4'd8, 64'h0, 64'h0, 1'b0},
      '{4'd2,  1'b1, 1'b1, 16'h0010, 4'd4, 64'h0000_0000_AAAA_0001, 64'h0, 1'b0},
      '{4'd2,  1'b1, 1'b1, 16'h0014, 4'd4, 64'h0000_0000_0000_BEEF, 64'h0, 1'b0},
      '{4'd2,  1'b1, 1'b1, 16'h0018, 4'd4, 64'h0000_0000_1234_5678, 64'h0, 1'b0},
      '{4'd2,  1'b0, 1'b1, 16'h0010, 4'd4, 64'h0, 64'h0000_0000_AAAA_0001, 1'b0},
      '{4'd2,  1'b0, 1'b1, 16'h0014, 4'd4, 64'h0, 64'h0000_0000_0000_BEEF, 1'b0},
      '{4'd2,  1'b0, 1'b1, 16'h0018, 4'd4, 64'h0, 64'h0000_0000_1234_5678, 1'b0},
      '{4'd3,  1'b0, 1'b1, 16'h0010, 4'd8, 64'h0, 64'h0000_BEEF_AAAA_0001, 1'b0},
      '{4'd3,  1'b1, 1'b1, 16'h0028, 4'd8, 64'hFFFF_FFFF_CAFE_F00D, 64'h0, 1'b0},
      '{4'd4,  1'b0, 1'b1, 16'h002C, 4'd4, 64'h0, 64'h0000_0000_0000_0001, 1'b0},
      '{4'd3,  1'b0, 1'b1, 16'h0028, 4'd8, 64'h0, 64'h0000_0001_CAFE_F00D, 1'b0},
      '{4'd3,  1'b1, 1'b1, 16'h0020, 4'd8, 64'h1111_2222_3333_4444, 64'h0, 1'b0},
      '{4'd3,  1'b0, 1'b1, 16'h0024, 4'd4, 64'h0, 64'h0000_0000_1111_2222, 1'b0},
      '{4'd10, 1'b0, 1'b1, 16'h0022, 4'd4, 64'h0, 64'h0, 1'b1},
      '{4'd10, 1'b0, 1'b1, 16'h0024, 4'd8, 64'h0, 64'h0, 1'b1},
      '{4'd10, 1'b1, 1'b1, 16'h0020, 4'd2, 64'hFFFF, 64'h0, 1'b1},
      '{4'd10, 1'b0, 1'b1, 16'h0020, 4'd4, 64'h0, 64'h0000_0000_3333_4444, 1'b0},
      '{4'd10, 1'b0, 1'b1, 16'h0100, 4'd4, 64'h0, 64'h0, 1'b1},
      '{4'd6,  1'b1, 1'b0, 16'h0000, 4'd4, 64'hFFFF_FFFF, 64'h0, 1'b1},
      '{4'd6,  1'b0, 1'b0, 16'h0000, 4'd4, 64'h0, 64'h0000_0000_000F_0011, 1'b0},
      '{4'd6,  1'b1, 1'b0, 16'h0002, 4'd2, 64'hC000, 64'h0, 1'b0},
      '{4'd5,  1'b0, 1'b0, 16'h0000, 4'd4, 64'h0, 64'h0000_0000_C00F_0011, 1'b0},
      '{4'd6,  1'b1, 1'b0, 16'h0002, 4'd2, 64'h3FFF, 64'h0, 1'b0},
      '{4'd6,  1'b0, 1'b0, 16'h0000, 4'd4, 64'h0, 64'h0000_0000_000F_0011, 1'b0},
      '{4'd10, 1'b0, 1'b0, 16'h000C, 4'd4, 64'h0, 64'h0, 1'b1},
      '{4'd4,  1'b1, 1'b1, 16'h003C, 4'd4, 64'hFFFF_FFFE, 64'h0, 1'b0},
      '{4'd4,  1'b0, 1'b1, 16'h003C, 4'd4, 64'h0, 64'h0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic        acc_table = 1'b0;
   logic [15:0] acc_offset = '0;
   logic [3:0]  acc_size = '0;
   logic [63:0] acc_wdata = '0;
   logic        rsp_valid;
   logic [63:0] rsp_rdata;
   logic        rsp_err;
   logic        msix_en;
   logic        fn_mask;
   logic [11:0] qry_idx = '0;
   logic        qry_masked;
   logic [63:0] qry_addr;
   logic [31:0] qry_data;
   logic        route_upd;
   logic [3:0]  route_idx;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   msix_regs u_msix_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_valid  (acc_valid),
      .acc_write  (acc_write),
      .acc_table  (acc_table),
      .acc_offset (acc_offset),
      .acc_size   (acc_size),
      .acc_wdata  (acc_wdata),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata),
      .rsp_err    (rsp_err),
      .msix_en    (msix_en),
      .fn_mask    (fn_mask),
      .qry_idx    (qry_idx),
      .qry_masked (qry_masked),
      .qry_addr   (qry_addr),
      .qry_data   (qry_data),
      .route_upd  (route_upd),
      .route_idx  (route_idx)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Drive one request for a single rising edge; return at the next falling edge.
   task automatic access(input bit wr, input bit tbl, input logic [15:0] off,
                         input logic [3:0] sz, input logic [63:0] wd);
      @(negedge clk);
      acc_valid  = 1'b1;
      acc_write  = wr;
      acc_table  = tbl;
      acc_offset = off;
      acc_size   = sz;
      acc_wdata  = wd;
      @(negedge clk);
      acc_valid  = 1'b0;
      acc_wdata  = '0;
   endtask

   initial begin
      repeat (25000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state, sampled while reset is held
      chk(!msix_en && !fn_mask, "R1", "enable/mask in reset",
          {62'd0, msix_en, fn_mask}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      qry_idx = 12'd5;
      #1;
      chk(!rsp_valid && !route_upd, "R1", "no response/route after reset",
          {62'd0, rsp_valid, route_upd}, 64'd0);
      chk(!qry_masked && qry_addr == 64'd0 && qry_data == 32'd0, "R1",
          "vector 5 cleared", qry_addr | {31'd0, qry_masked, qry_data}, 64'd0);

      // Table-driven walk
      for (int i = 0; i < NV; i++) begin
         access(VECS[i].wr, VECS[i].tbl, VECS[i].off, VECS[i].sz, VECS[i].wd);
         chk(rsp_valid && rsp_err == VECS[i].err && rsp_rdata == VECS[i].exp &&
             !route_upd, $sformatf("R%0d", VECS[i].req),
             $sformatf("vector %0d", i), rsp_rdata, VECS[i].exp);
      end

      // R11: no response while idle
      @(negedge clk);
      chk(!rsp_valid, "R11", "idle response", {63'd0, rsp_valid}, 64'd0);

      // R2 R3 R4: query port reflects stored entries
      qry_idx = 12'd1; #1;
      chk(!qry_masked && qry_addr == 64'h0000_BEEF_AAAA_0001 && qry_data == 32'h1234_5678,
          "R2", "query vector 1", qry_addr, 64'h0000_BEEF_AAAA_0001);
      qry_idx = 12'd2; #1;
      chk(qry_masked && qry_data == 32'hCAFE_F00D, "R4", "query vector 2 masked",
          {31'd0, qry_masked, qry_data}, {31'd0, 1'b1, 32'hCAFE_F00D});
      qry_idx = 12'd3; #1;
      chk(!qry_masked, "R4", "only bit 0 sets the mask", {63'd0, qry_masked}, 64'd0);
      // R8: out-of-range queries
      qry_idx = 12'd16; #1;
      chk(qry_masked && qry_addr == 64'd0, "R8", "query index 16",
          {63'd0, qry_masked}, 64'd1);
      qry_idx = 12'd2047; #1;
      chk(qry_masked && qry_data == 32'd0, "R8", "query index 2047",
          {63'd0, qry_masked}, 64'd1);

      // R9: route notification
      access(1'b1, 1'b0, 16'h0002, 4'd2, 64'h8000);
      chk(msix_en && !fn_mask, "R6", "enable set alone",
          {62'd0, msix_en, fn_mask}, 64'd2);
      access(1'b1, 1'b1, 16'h0018, 4'd4, 64'h1234_5678);
      chk(!route_upd, "R9", "unchanged data gives no pulse", {63'd0, route_upd}, 64'd0);
      access(1'b1, 1'b1, 16'h0018, 4'd4, 64'h8765_4321);
      chk(route_upd && route_idx == 4'd1, "R9", "data change pulse idx 1",
          {59'd0, route_upd, route_idx}, {59'd0, 1'b1, 4'd1});
      @(negedge clk);
      chk(!route_upd, "R9", "pulse lasts one cycle", {63'd0, route_upd}, 64'd0);
      access(1'b1, 1'b1, 16'h001C, 4'd4, 64'h1);
      chk(!route_upd, "R9", "vector control write no pulse", {63'd0, route_upd}, 64'd0);
      qry_idx = 12'd1; #1;
      chk(qry_masked, "R4", "vector 1 masked by control write", {63'd0, qry_masked}, 64'd1);
      access(1'b1, 1'b1, 16'h0030, 4'd8, 64'h0000_0000_0000_0001);
      chk(route_upd && route_idx == 4'd3, "R9", "qword address pulse idx 3",
          {59'd0, route_upd, route_idx}, {59'd0, 1'b1, 4'd3});
      access(1'b1, 1'b0, 16'h0002, 4'd2, 64'h0000);
      access(1'b1, 1'b1, 16'h0034, 4'd4, 64'h55);
      chk(!route_upd, "R9", "disabled write no pulse", {63'd0, route_upd}, 64'd0);
      access(1'b0, 1'b1, 16'h0034, 4'd4, 64'h0);
      chk(rsp_rdata == 64'h55, "R2", "address high of vector 3", rsp_rdata, 64'h55);

      // R6 R5: function mask alone
      access(1'b1, 1'b0, 16'h0002, 4'd2, 64'h4000);
      chk(!msix_en && fn_mask, "R6", "function mask set alone",
          {62'd0, msix_en, fn_mask}, 64'd1);
      access(1'b0, 1'b0, 16'h0000, 4'd4, 64'h0);
      chk(rsp_rdata == 64'h0000_0000_400F_0011, "R5", "control word with mask",
          rsp_rdata, 64'h0000_0000_400F_0011);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule